// File: doc/BRIEF.md
# Programmable Baud Rate Divider with Byte-Wide Register Access

This block is the baud-rate generator of one serial channel, together with the small piece of register space that programs it. A host reads and writes 8-bit registers through a 3-bit offset, a write strobe and a read strobe. Two divisor bytes, low and high, form a 16-bit divisor. A down-counter divides the enabled input clock by that divisor and produces a one-cycle tick at sixteen times the wanted baud rate. For example, with a 1.8432 MHz enabled clock, a divisor of 12 gives 9600 baud and a divisor of 1 gives 115200 baud.

A line-control byte decides whether the two divisor offsets reach the divisor bytes or are passed to the rest of the channel through an external register port. A scratch byte gives software a free storage location. Every offset the block does not own goes to the external port. A prescaler-select bit is carried through unchanged. The divisor bytes are left out of the master reset, so the programmed rate survives a reset. Only the counter restarts.

The counter is controlled by a two-state machine. ST_PRIME is the state after reset. It leaves on the "prime" transition to ST_RUN at the first clock edge, loading the counter from the stored divisor. ST_RUN stays in ST_RUN through three named transitions. "count" decrements the counter on an enabled cycle. "expire" emits the tick and reloads the counter from the stored divisor. "reload" is taken on any divisor write and loads the counter from the newly written divisor, with priority over the other two.

Top module: `baud_divisor_unit`

## Requirements
- R1: The divisor D is {high byte, low byte}. For D from 1 to 65535, with `baud_clk_en` held high, `baud_tick` pulses once every D clock cycles. With D = 1, it is high on every cycle.
- R2: A write to the low or high divisor byte reloads the counter at once. No tick occurs in the write cycle. With the enable held high, the first tick comes D cycles after the write cycle, where D is the new combined divisor.
- R3: A divisor of 0 acts as 65536, so the tick keeps running with a period of 65536 enabled cycles.
- R4: The counter advances only on cycles where `baud_clk_en` is high. A tick is issued only on such a cycle, on the D-th enabled cycle, and it lasts one cycle when D is at least 2.
- R5: The low divisor byte is at offset 0 and the high byte at offset 1. Both can be read and written while line-control bit 7 is 1 and the line-control byte is not 0xBF.
- R6: While the gate of R5 is closed, accesses to offsets 0 and 1 go to the external port: `ext_wr` or `ext_rd` is asserted and read data comes from `ext_rdata`. The divisor bytes keep their values.
- R7: Offsets 2, 4, 5 and 6 always go to the external port. Offset and write data are passed straight through.
- R8: The line-control byte is at offset 3. It is read/write and resets to 0x00.
- R9: The scratch byte is at offset 7. It is read/write, resets to 0xFF, and writing it does not shift the tick timing.
- R10: Master reset leaves both divisor bytes unchanged. With the enable held high, the first tick comes D cycles after the cycle in which reset is released.
- R11: `presc_sel_out` follows `presc_sel_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational |
| ext_addr | output | 3 | Offset passed to the external register port |
| ext_wdata | output | 8 | Write data passed to the external port |
| ext_wr | output | 1 | Write strobe for an access routed outside |
| ext_rd | output | 1 | Read strobe for an access routed outside |
| ext_rdata | input | 8 | Read data returned by the external port |
| baud_clk_en | input | 1 | Clock enable from the prescaler |
| presc_sel_in | input | 1 | Prescaler select in |
| presc_sel_out | output | 1 | Prescaler select out |
| baud_tick | output | 1 | One-cycle tick at 16x the baud rate |

## Verification
The divider is driven with a divisor of 1, which separates the every-cycle case from off-by-one errors. Divisors of 12 and 268 are also used, with the second reached through a high-byte write, which shows that each byte triggers its own reload. A divisor of 0 confirms the 65536 wrap instead of a stall. An enable that is high only every third cycle shows that counting follows enabled cycles and not raw clock cycles. A scratch write in the middle of a period, gated accesses with line-control values 0x03 and 0xBF, and a master reset followed by a read-back distinguish the routing decode and the retained divisor from the counter restart.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    typedef enum logic [2:0] {
        SEL_DIV_LO,
        SEL_DIV_HI,
        SEL_LINE,
        SEL_SCRATCH,
        SEL_EXTERNAL
    } reg_sel_e;

    typedef enum logic {
        ST_PRIME,
        ST_RUN
    } tick_state_e;

endpackage

// File: rtl/baud_access_decode.sv
module baud_access_decode
    import baud_div_pkg::*;
#(
    parameter int unsigned         ADDR_W    = 3,
    parameter int unsigned         DATA_W    = 8,
    parameter logic [ADDR_W-1:0]   DLL_OFF   = 3'd0,
    parameter logic [ADDR_W-1:0]   DLM_OFF   = 3'd1,
    parameter logic [ADDR_W-1:0]   LCR_OFF   = 3'd3,
    parameter logic [ADDR_W-1:0]   SCR_OFF   = 3'd7,
    parameter int unsigned         GATE_BIT  = 7,
    parameter logic [DATA_W-1:0]   LOCK_CODE = 8'hBF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] line_ctl,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              ext_rd,
    output logic              ext_wr
);

    logic gate_open;

    // divisor bytes are visible only with the gate bit set and not the lock code
    always_comb begin
        gate_open = line_ctl[GATE_BIT] && (line_ctl != LOCK_CODE);
        if (gate_open && addr == DLL_OFF) begin
            sel = SEL_DIV_LO;
        end else if (gate_open && addr == DLM_OFF) begin
            sel = SEL_DIV_HI;
        end else if (addr == LCR_OFF) begin
            sel = SEL_LINE;
        end else if (addr == SCR_OFF) begin
            sel = SEL_SCRATCH;
        end else begin
            sel = SEL_EXTERNAL;
        end
    end

    always_comb begin
        ext_rd = rd && (sel == SEL_EXTERNAL);
        ext_wr = wr && (sel == SEL_EXTERNAL);
    end

endmodule

// File: rtl/baud_regbank.sv
module baud_regbank
    import baud_div_pkg::*;
#(
    parameter int unsigned       DATA_W  = 8,
    parameter logic [DATA_W-1:0] LCR_RST = 8'h00,
    parameter logic [DATA_W-1:0] SCR_RST = 8'hFF,
    localparam int unsigned      DIV_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dll_q,
    output logic [DATA_W-1:0] dlm_q,
    output logic [DATA_W-1:0] lcr_q,
    output logic [DATA_W-1:0] scr_q,
    output logic              div_load,
    output logic [DIV_W-1:0]  div_next
);

    // control bytes follow master reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= LCR_RST;
            scr_q <= SCR_RST;
        end else if (wr_en) begin
            if (sel == SEL_LINE)    lcr_q <= wdata;
            if (sel == SEL_SCRATCH) scr_q <= wdata;
        end
    end

    // divisor bytes deliberately ignore master reset
    always_ff @(posedge clk) begin
        if (wr_en && sel == SEL_DIV_LO) dll_q <= wdata;
        if (wr_en && sel == SEL_DIV_HI) dlm_q <= wdata;
    end

    // combined divisor as it will be after this write, for the counter reload
    always_comb begin
        div_load = wr_en && (sel == SEL_DIV_LO || sel == SEL_DIV_HI);
        div_next = (sel == SEL_DIV_LO) ? {dlm_q, wdata} : {wdata, dll_q};
    end

endmodule

// File: rtl/baud_tick_counter.sv
module baud_tick_counter
    import baud_div_pkg::*;
#(
    parameter int unsigned  DIV_W = 16,
    localparam int unsigned CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             load,
    input  logic [DIV_W-1:0] load_div,
    input  logic [DIV_W-1:0] cur_div,
    output logic             tick
);

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // zero divisor stands for the full 2**DIV_W range
    function automatic logic [CNT_W-1:0] span(input logic [DIV_W-1:0] d);
        return (d == '0) ? (CNT_W'(1) << DIV_W) : {1'b0, d};
    endfunction

    always_comb begin
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_PRIME: cnt_q <= load ? span(load_div) : span(cur_div);
                ST_RUN: begin
                    if (load) begin
                        cnt_q <= span(load_div);
                    end else if (clk_en) begin
                        if (cnt_q == CNT_W'(1)) cnt_q <= span(cur_div);
                        else                     cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PRIME: tick = 1'b0;
            ST_RUN:   tick = clk_en && !load && (cnt_q == CNT_W'(1));
        endcase
    end

    assert_cnt_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));

    assert_tick_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cur_div != DIV_W'(1)) |=> !tick);

    assert_reload_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_div != DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/baud_divisor_unit.sv
module baud_divisor_unit
    import baud_div_pkg::*;
#(
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] DLL_OFF   = 3'd0,
    parameter logic [ADDR_W-1:0] DLM_OFF   = 3'd1,
    parameter logic [ADDR_W-1:0] LCR_OFF   = 3'd3,
    parameter logic [ADDR_W-1:0] SCR_OFF   = 3'd7,
    parameter int unsigned       GATE_BIT  = 7,
    parameter logic [DATA_W-1:0] LOCK_CODE = 8'hBF,
    parameter logic [DATA_W-1:0] LCR_RST   = 8'h00,
    parameter logic [DATA_W-1:0] SCR_RST   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_wr,
    output logic              ext_rd,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              baud_clk_en,
    input  logic              presc_sel_in,
    output logic              presc_sel_out,
    output logic              baud_tick
);

    localparam int unsigned DIV_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic [DATA_W-1:0] dll_q, dlm_q, lcr_q, scr_q;
    logic              div_load;
    logic [DIV_W-1:0]  div_next;
    logic [DIV_W-1:0]  divisor;

    baud_access_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DLL_OFF(DLL_OFF), .DLM_OFF(DLM_OFF), .LCR_OFF(LCR_OFF), .SCR_OFF(SCR_OFF),
        .GATE_BIT(GATE_BIT), .LOCK_CODE(LOCK_CODE)
    ) decode_i (
        .addr(reg_addr), .line_ctl(lcr_q), .rd(reg_rd), .wr(reg_wr),
        .sel(sel), .ext_rd(ext_rd), .ext_wr(ext_wr)
    );

    baud_regbank #(
        .DATA_W(DATA_W), .LCR_RST(LCR_RST), .SCR_RST(SCR_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
        .dll_q(dll_q), .dlm_q(dlm_q), .lcr_q(lcr_q), .scr_q(scr_q),
        .div_load(div_load), .div_next(div_next)
    );

    assign divisor = {dlm_q, dll_q};

    baud_tick_counter #(
        .DIV_W(DIV_W)
    ) counter_i (
        .clk(clk), .rst_n(rst_n), .clk_en(baud_clk_en), .load(div_load),
        .load_div(div_next), .cur_div(divisor), .tick(baud_tick)
    );

    always_comb begin
        ext_addr      = reg_addr;
        ext_wdata     = reg_wdata;
        presc_sel_out = presc_sel_in;
        unique case (sel)
            SEL_DIV_LO:   reg_rdata = dll_q;
            SEL_DIV_HI:   reg_rdata = dlm_q;
            SEL_LINE:     reg_rdata = lcr_q;
            SEL_SCRATCH:  reg_rdata = scr_q;
            SEL_EXTERNAL: reg_rdata = ext_rdata;
            default:      reg_rdata = ext_rdata;
        endcase
    end

    assert_div_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == DLL_OFF || reg_addr == DLM_OFF)
            && (!lcr_q[GATE_BIT] || lcr_q == LOCK_CODE)) |=> $stable(divisor));

    assert_ext_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != DLL_OFF && reg_addr != DLM_OFF
            && reg_addr != LCR_OFF && reg_addr != SCR_OFF) |-> ext_wr);

endmodule

// File: tb/baud_divisor_unit_tb_top.sv
`timescale 1ns/1ps
module baud_divisor_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_rdata;
    logic [2:0] ext_addr;
    logic [7:0] ext_wdata;
    logic       ext_wr, ext_rd;
    logic [7:0] ext_rdata;
    logic       baud_clk_en;
    logic       presc_sel_in, presc_sel_out;
    logic       baud_tick;

    always #2.5 clk = ~clk;

    baud_divisor_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_rdata(ext_rdata), .baud_clk_en(baud_clk_en),
        .presc_sel_in(presc_sel_in), .presc_sel_out(presc_sel_out), .baud_tick(baud_tick)
    );

    int cyc = 0;
    int en_mode = 0;
    int n_chk = 0;
    int n_err = 0;
    bit tick_mon = 1'b0;
    bit done = 1'b0;
    logic wr_tick;
    string tick_tag = "R1";

    int    tick_q[$];
    logic [7:0] rd_q[$];
    string rd_tag_q[$];
    logic [11:0] ext_q[$];
    string ext_tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;
    assign baud_clk_en = (en_mode == 0) || (cyc % 3 == 0);

    function automatic bit en_of(int c);
        return (en_mode == 0) || (c % 3 == 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares design activity against the scoreboard queues
    int   m_exp_c;
    logic [7:0] m_exp_d;
    logic [11:0] m_exp_x;
    string m_tag;
    always @(negedge clk) begin
        if (tick_mon && baud_tick) begin
            if (tick_q.size() == 0) chk(1'b0, {tick_tag, " unexpected tick"}, cyc, -1);
            else begin
                m_exp_c = tick_q.pop_front();
                chk(cyc == m_exp_c, {tick_tag, " tick cycle"}, cyc, m_exp_c);
            end
        end
        if (reg_rd) begin
            if (rd_q.size() == 0) chk(1'b0, "R5 unexpected read", reg_rdata, 0);
            else begin
                m_exp_d = rd_q.pop_front();
                m_tag = rd_tag_q.pop_front();
                chk(reg_rdata == m_exp_d, {m_tag, " read data"}, reg_rdata, m_exp_d);
            end
        end
        if (ext_wr || ext_rd) begin
            if (ext_q.size() == 0) chk(1'b0, "R6 unexpected external access", {ext_wr, ext_addr, ext_wdata}, 0);
            else begin
                m_exp_x = ext_q.pop_front();
                m_tag = ext_tag_q.pop_front();
                chk({ext_wr, ext_addr, ext_wdata} == m_exp_x, {m_tag, " external access"},
                    {ext_wr, ext_addr, ext_wdata}, m_exp_x);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, output int w);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; w = cyc;
        @(negedge clk); #0.5;
        wr_tick = baud_tick;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rd_q.push_back(exp); rd_tag_q.push_back(tag);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic expect_ticks(input int w, input int d, input int n, input string tag);
        int c;
        int last;
        c = w; last = w;
        tick_tag = tag;
        for (int k = 0; k < n; k++) begin
            int seen;
            seen = 0;
            while (seen < d) begin
                c++;
                if (en_of(c)) seen++;
            end
            tick_q.push_back(c);
            last = c;
        end
        tick_mon = 1'b1;
        do @(negedge clk); while (cyc < last);
        #1;
        chk(tick_q.size() == 0, {tag, " missing ticks"}, tick_q.size(), 0);
        tick_q.delete();
        tick_mon = 1'b0;
    endtask

    task automatic ext_expect(input bit is_wr, input logic [2:0] a, input logic [7:0] d, input string tag);
        ext_q.push_back({is_wr, a, d});
        ext_tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired, all requirements at risk");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int w;
        int r;
        rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        ext_rdata = 8'h5A; presc_sel_in = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state R8, R9; pass-through R11
        rd_reg(3'd7, 8'hFF, "R9 scratch reset");
        rd_reg(3'd3, 8'h00, "R8 line-control reset");
        presc_sel_in = 1'b1; #1;
        chk(presc_sel_out == 1'b1, "R11 prescaler select high", presc_sel_out, 1);
        presc_sel_in = 1'b0; #1;
        chk(presc_sel_out == 1'b0, "R11 prescaler select low", presc_sel_out, 0);

        // open the divisor gate, divisor 1: tick every cycle (R1)
        wr_reg(3'd3, 8'h80, w);
        rd_reg(3'd3, 8'h80, "R8 line-control write");
        wr_reg(3'd1, 8'h00, w);
        wr_reg(3'd0, 8'h01, w);
        expect_ticks(w, 1, 5, "R1 divisor 1");

        // divisor 12: write cycle shows no tick, then period 12 (R1, R2)
        wr_reg(3'd0, 8'h0C, w);
        chk(wr_tick == 1'b0, "R2 no tick in write cycle", wr_tick, 0);
        expect_ticks(w, 12, 4, "R2 divisor 12");
        rd_reg(3'd0, 8'h0C, "R5 low byte read");
        rd_reg(3'd1, 8'h00, "R5 high byte read");

        // high-byte write alone reloads: D = 0x010C (R2)
        wr_reg(3'd1, 8'h01, w);
        expect_ticks(w, 268, 2, "R2 high byte reload");

        // scratch write mid-period leaves tick phase alone (R9)
        wr_reg(3'd1, 8'h00, w);
        fork
            expect_ticks(w, 12, 3, "R9 scratch no effect");
            begin
                wr_reg(3'd7, 8'hA5, r);
                rd_reg(3'd7, 8'hA5, "R9 scratch write");
            end
        join

        // gate closed by bit 7 low (R6)
        wr_reg(3'd3, 8'h03, w);
        ext_expect(1'b1, 3'd0, 8'h33, "R6 gated low byte write");
        wr_reg(3'd0, 8'h33, w);
        ext_expect(1'b0, 3'd1, 8'h33, "R6 gated high byte read");
        rd_reg(3'd1, 8'h5A, "R6 gated read data");
        // gate closed by lock code (R6)
        wr_reg(3'd3, 8'hBF, w);
        ext_expect(1'b1, 3'd1, 8'h77, "R6 locked high byte write");
        wr_reg(3'd1, 8'h77, w);
        wr_reg(3'd3, 8'h80, w);
        rd_reg(3'd0, 8'h0C, "R6 low byte kept");
        rd_reg(3'd1, 8'h00, "R6 high byte kept");

        // unowned offsets always external (R7)
        for (int a = 2; a < 7; a++) begin
            if (a != 3) begin
                ext_expect(1'b1, 3'(a), 8'(8'h10 + a), "R7 external write");
                wr_reg(3'(a), 8'(8'h10 + a), w);
                ext_expect(1'b0, 3'(a), 8'(8'h10 + a), "R7 external read");
                rd_reg(3'(a), 8'h5A, "R7 external read data");
            end
        end

        // enable high one cycle in three (R4)
        en_mode = 1;
        wr_reg(3'd0, 8'h05, w);
        expect_ticks(w, 5, 3, "R4 gated enable");
        en_mode = 0;

        // zero divisor runs as 65536 (R3)
        wr_reg(3'd0, 8'h00, w);
        wr_reg(3'd1, 8'h00, w);
        expect_ticks(w, 65536, 1, "R3 divisor zero");

        // retention through master reset (R10)
        wr_reg(3'd0, 8'h07, w);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1; r = cyc;
        fork
            expect_ticks(r, 7, 4, "R10 restart after reset");
            begin
                rd_reg(3'd7, 8'hFF, "R9 scratch after reset");
                wr_reg(3'd3, 8'h80, w);
                rd_reg(3'd0, 8'h07, "R10 low byte kept");
                rd_reg(3'd1, 8'h00, "R10 high byte kept");
            end
        join

        repeat (2) @(posedge clk);
        #1;
        chk(rd_q.size() == 0, "R5 reads outstanding", rd_q.size(), 0);
        chk(ext_q.size() == 0, "R6 external accesses missing", ext_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule